// File: doc/BRIEF.md
# Converter Host Bus Interface

This block is the processor-facing control logic of a parallel-output analog-to-digital converter. It takes the host strobes: chip select, sample/hold, read and output enable. It turns them into a single-cycle start request for the converter core, and it reports completion through an end-of-conversion flag and an active-low interrupt. The block holds the finished 12-bit result in a register and decides when that result may be driven onto the host data bus.

There are two host modes. In interrupt mode the host starts a conversion, waits for the interrupt, and then reads the result with chip select, read and output enable all low. The falling edge of read clears the interrupt. In high-speed mode the latest result is always driven on the bus, so the host never waits on an interrupt-to-read step. All host strobes and the mode select are asynchronous to the block clock and pass through two-flop synchronizers. The converter core is synchronous to the block clock.

Top module: `adc_host_if`

## Requirements
- R1: A falling edge of `sh_n` while `cs_n` is low raises `start_conv` for exactly one cycle and clears `eoc`. Counting from the first rising clock edge that samples the new `sh_n` level, `start_conv` is high after the third edge.
- R2: A falling edge of `sh_n` while `cs_n` is high starts no conversion and leaves `eoc` unchanged.
- R3: A falling edge of `sh_n` while a conversion is in progress (after `start_conv` and before `core_done`) is ignored.
- R4: When `core_done` is high during a conversion in progress, the block captures `core_result` on `dout` and sets `eoc` high on the next clock edge.
- R5: In interrupt mode (`fast_mode` = 0), `int_n` goes low at the edge where `eoc` rises. In high-speed mode (`fast_mode` = 1), `int_n` never goes low.
- R6: A falling edge of `rd_n` while `cs_n` is low sets `int_n` high. With `cs_n` high, a falling edge of `rd_n` leaves `int_n` unchanged.
- R7: In interrupt mode, `dout_en` is high only when the synchronized `cs_n`, `rd_n` and `oe_n` are all low. If any of them is high, `dout_en` is low.
- R8: In high-speed mode, `dout_en` is high at all times.
- R9: `dout` changes only when a conversion completes, and holds its value while a new conversion runs.
- R10: During reset, `eoc` = 0, `int_n` = 1, `dout` = 0, `dout_en` = 0 and `start_conv` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sh_n | input | 1 | Sample/hold; a falling edge starts a conversion |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| fast_mode | input | 1 | 1 = high-speed mode, 0 = interrupt mode |
| core_done | input | 1 | Conversion-complete strobe from the core |
| core_result | input | 12 | Conversion result from the core |
| start_conv | output | 1 | One-cycle start request to the core |
| eoc | output | 1 | End of conversion, high while a result is valid |
| int_n | output | 1 | Active-low interrupt |
| dout | output | 12 | Latched conversion result |
| dout_en | output | 1 | Drive enable for the host data bus |

## Verification
The assertions check the following on every cycle:
- `start_conv` is a single-cycle pulse, and `eoc` is low with it.
- No start is issued while a conversion is in progress.
- `dout` holds its value in every cycle that did not complete a conversion.
- High-speed mode keeps `dout_en` high and never drops the interrupt.
- In interrupt mode, the bus is enabled only after chip select, read and output enable were all low.

Some behaviour only the bench scenarios can show:
- The three-edge start latency.
- That a gated or overlapping sample/hold edge is really dropped.
- That the captured value matches the core data.
- How the interrupt responds to reads with and without chip select.

// File: rtl/adc_host_pkg.sv
// Package: shared constants for the converter host interface.
// Assumes: strobe order below is used by the synchronizer vector in the top.
package adc_host_pkg;
    localparam int DATA_W      = 12;
    localparam int SYNC_STAGES = 2;
    // bit positions of the asynchronous inputs inside the synchronizer vector
    localparam int STB_CS   = 0;
    localparam int STB_SH   = 1;
    localparam int STB_RD   = 2;
    localparam int STB_OE   = 3;
    localparam int STB_FAST = 4;
    localparam int NUM_STB  = 5;
    // idle levels: strobes idle high, mode select idles in interrupt mode
    localparam logic [NUM_STB-1:0] STB_IDLE = 5'b0_1111;
endpackage

// File: rtl/adc_host_sync.sv
// Module: multi-bit multi-stage synchronizer, one independent chain per bit.
// Assumes: each bit is a slow level (strobe) held for several clock cycles;
// reset loads each chain with the bit's idle level so no false edge appears.
module adc_host_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            // shift the raw input through STAGES flops
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
                else        chain <= {chain[STAGES-2:0], d[b]};
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/adc_host_ctrl.sv
// Module: conversion sequencer and interrupt flag.
// Does: detects gated sample/hold and read falling edges, issues a start
// pulse, tracks busy, captures the core result, drives eoc and int_n.
// Assumes: all strobe inputs already synchronized; core is on clk.
module adc_host_ctrl #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sh_s,
    input  logic              rd_s,
    input  logic              fast_s,
    input  logic              core_done,
    input  logic [DATA_W-1:0] core_result,
    output logic              start_conv,
    output logic              busy,
    output logic              eoc,
    output logic              int_n,
    output logic [DATA_W-1:0] result
);
    logic sh_prev, rd_prev;
    logic sh_fall, rd_fall, done_evt;

    assign sh_fall  = sh_prev & ~sh_s & ~cs_s;
    assign rd_fall  = rd_prev & ~rd_s & ~cs_s;
    assign done_evt = busy & core_done;

    // remember previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_prev <= 1'b1;
            rd_prev <= 1'b1;
        end else begin
            sh_prev <= sh_s;
            rd_prev <= rd_s;
        end
    end

    // start, busy tracking, result capture and end-of-conversion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_conv <= 1'b0;
            busy       <= 1'b0;
            eoc        <= 1'b0;
            result     <= '0;
        end else begin
            start_conv <= 1'b0;
            if (sh_fall && !busy) begin
                start_conv <= 1'b1;
                busy       <= 1'b1;
                eoc        <= 1'b0;
            end else if (done_evt) begin
                busy   <= 1'b0;
                eoc    <= 1'b1;
                result <= core_result;
            end
        end
    end

    // interrupt: set on completion in interrupt mode, cleared by gated read edge
    always_ff @(posedge clk) begin
        if (!rst_n)                  int_n <= 1'b1;
        else if (done_evt && !fast_s) int_n <= 1'b0;
        else if (rd_fall)             int_n <= 1'b1;
    end
endmodule

// File: rtl/adc_host_bus.sv
// Module: data bus drive-enable decode.
// Does: enables the bus always in high-speed mode, else only when chip
// select, read and output enable are all low. Assumes synchronized inputs.
module adc_host_bus (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_s,
    input  logic cs_s,
    input  logic rd_s,
    input  logic oe_s,
    output logic dout_en
);
    // registered enable decode
    always_ff @(posedge clk) begin
        if (!rst_n) dout_en <= 1'b0;
        else        dout_en <= fast_s | (~cs_s & ~rd_s & ~oe_s);
    end
endmodule

// File: rtl/adc_host_if.sv
// Module: top of the converter host bus interface.
// Does: synchronizes host strobes, sequences conversions, latches results
// and decodes the bus enable for interrupt and high-speed modes.
// Assumes: core_done/core_result are synchronous to clk.
module adc_host_if
    import adc_host_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sh_n,
    input  logic         rd_n,
    input  logic         oe_n,
    input  logic         fast_mode,
    input  logic         core_done,
    input  logic [W-1:0] core_result,
    output logic         start_conv,
    output logic         eoc,
    output logic         int_n,
    output logic [W-1:0] dout,
    output logic         dout_en
);
    logic [NUM_STB-1:0] raw, synced;
    logic cs_s, sh_s, rd_s, oe_s, fast_s, busy;

    assign raw[STB_CS]   = cs_n;
    assign raw[STB_SH]   = sh_n;
    assign raw[STB_RD]   = rd_n;
    assign raw[STB_OE]   = oe_n;
    assign raw[STB_FAST] = fast_mode;

    assign cs_s   = synced[STB_CS];
    assign sh_s   = synced[STB_SH];
    assign rd_s   = synced[STB_RD];
    assign oe_s   = synced[STB_OE];
    assign fast_s = synced[STB_FAST];

    adc_host_sync #(.WIDTH(NUM_STB), .STAGES(STAGES), .RST_VAL(STB_IDLE)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    adc_host_ctrl #(.DATA_W(W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sh_s(sh_s), .rd_s(rd_s),
        .fast_s(fast_s), .core_done(core_done), .core_result(core_result),
        .start_conv(start_conv), .busy(busy), .eoc(eoc), .int_n(int_n),
        .result(dout)
    );

    adc_host_bus i_bus (
        .clk(clk), .rst_n(rst_n), .fast_s(fast_s), .cs_s(cs_s),
        .rd_s(rd_s), .oe_s(oe_s), .dout_en(dout_en)
    );
endmodule

// File: rtl/adc_host_if_chk.sv
// Module: protocol checker bound to adc_host_if.
module adc_host_if_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_conv,
    input logic         eoc,
    input logic         int_n,
    input logic [W-1:0] dout,
    input logic         dout_en,
    input logic         core_done,
    input logic         busy,
    input logic         fast_s,
    input logic         cs_s,
    input logic         rd_s,
    input logic         oe_s
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |=> !start_conv); // R1
    AST_START_CLEARS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |-> !eoc); // R1
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |-> !$past(busy)); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(core_done) |-> $stable(dout)); // R9
    AST_FAST_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> !$past(fast_s)); // R5
    AST_FAST_BUS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fast_s) |-> dout_en); // R8
    AST_IRQ_BUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && !$past(fast_s)) |-> $past(!cs_s && !rd_s && !oe_s)); // R7
endmodule

bind adc_host_if adc_host_if_chk #(.W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .start_conv(start_conv), .eoc(eoc),
    .int_n(int_n), .dout(dout), .dout_en(dout_en), .core_done(core_done),
    .busy(busy), .fast_s(fast_s), .cs_s(cs_s), .rd_s(rd_s), .oe_s(oe_s)
);

// File: tb/test_adc_host_if.sv
`timescale 1ns/1ps
module test_adc_host_if;
    localparam int W = 12;

    typedef struct packed {
        logic         fast;
        logic [W-1:0] data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 12'hA5C}, '{1'b0, 12'h000}, '{1'b1, 12'hFFF}, '{1'b1, 12'h123},
        '{1'b0, 12'h800}, '{1'b1, 12'h001}, '{1'b0, 12'h7FF}, '{1'b0, 12'h3C3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sh_n = 1'b1, rd_n = 1'b1, oe_n = 1'b1, fast_mode = 1'b0;
    logic core_done = 1'b0;
    logic [W-1:0] core_result = '0;
    logic start_conv, eoc, int_n, dout_en;
    logic [W-1:0] dout;

    int checks = 0, errors = 0, n_start = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_host_if i_adc_host_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sh_n(sh_n), .rd_n(rd_n),
        .oe_n(oe_n), .fast_mode(fast_mode), .core_done(core_done),
        .core_result(core_result), .start_conv(start_conv), .eoc(eoc),
        .int_n(int_n), .dout(dout), .dout_en(dout_en)
    );

    always @(negedge clk) if (start_conv) n_start++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // full conversion with cs low: checks start latency and capture
    task automatic convert(input logic [W-1:0] data);
        sh_n = 1'b0;
        tick(2);
        check("R1 latency (no start yet)", start_conv, 0);
        tick(1);
        check("R1 start pulse", start_conv, 1);
        check("R1 eoc low at start", eoc, 0);
        tick(1);
        sh_n = 1'b1;
        tick(2);
        core_result = data;
        core_done = 1'b1;
        tick(1);
        core_done = 1'b0;
        tick(1);
        check("R4 eoc high", eoc, 1);
        check("R4 captured result", dout, data);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s0;
        logic [W-1:0] held;
        tick(3);
        check("R10 eoc reset", eoc, 0);
        check("R10 int_n reset", int_n, 1);
        check("R10 dout reset", dout, 0);
        check("R10 dout_en reset", dout_en, 0);
        check("R10 start_conv reset", start_conv, 0);
        rst_n = 1'b1;
        cs_n = 1'b0;
        tick(4);

        // vector table walk
        foreach (VECS[i]) begin
            fast_mode = VECS[i].fast;
            tick(4);
            convert(VECS[i].data);
            check("R5 int_n after completion", int_n, VECS[i].fast ? 1 : 0);
            check("R7/R8 bus enable idle", dout_en, VECS[i].fast);
            rd_n = 1'b0; oe_n = 1'b0;
            tick(4);
            check("R6 read clears int_n", int_n, 1);
            check("R7 bus enabled during read", dout_en, 1);
            rd_n = 1'b1; oe_n = 1'b1;
            tick(4);
            check("R7/R8 bus enable after read", dout_en, VECS[i].fast);
            check("R9 result held after read", dout, VECS[i].data);
        end

        // interrupt mode, pending interrupt
        fast_mode = 1'b0;
        tick(4);
        convert(12'h5A5);
        check("R5 interrupt pending", int_n, 0);

        // R7: read low but output enable high -> no drive
        rd_n = 1'b0;
        tick(4);
        check("R7 oe high keeps bus off", dout_en, 0);
        check("R6 read with cs low clears int", int_n, 1);
        rd_n = 1'b1;
        tick(4);

        // R2 and R6: strobes with chip select high
        convert(12'h0F0);
        cs_n = 1'b1;
        tick(4);
        s0 = n_start;
        sh_n = 1'b0; tick(4); sh_n = 1'b1; tick(4);
        check("R2 no start with cs high", n_start, s0);
        check("R2 eoc unchanged", eoc, 1);
        rd_n = 1'b0; oe_n = 1'b0;
        tick(4);
        check("R6 read with cs high ignored", int_n, 0);
        check("R7 cs high keeps bus off", dout_en, 0);
        rd_n = 1'b1; oe_n = 1'b1;
        cs_n = 1'b0;
        tick(4);

        // R3 and R9: second sample edge during a conversion
        held = dout;
        s0 = n_start;
        sh_n = 1'b0; tick(4); sh_n = 1'b1; tick(4);
        check("R9 dout held while converting", dout, held);
        check("R1 eoc low while converting", eoc, 0);
        sh_n = 1'b0; tick(4); sh_n = 1'b1; tick(4);
        check("R3 overlapping start ignored", n_start, s0 + 1);
        core_result = 12'hBEE; core_done = 1'b1;
        tick(1);
        core_done = 1'b0;
        tick(1);
        check("R4 capture after overlap", dout, 12'hBEE);
        check("R3 eoc after overlap", eoc, 1);

        // R4: core_done with no conversion in progress changes nothing
        core_result = 12'h111; core_done = 1'b1;
        tick(1);
        core_done = 1'b0;
        tick(2);
        check("R4 stray done ignored", dout, 12'hBEE);

        // R8: fast mode enables bus without any read
        fast_mode = 1'b1;
        tick(4);
        check("R8 fast mode bus on", dout_en, 1);
        tick(2);
        finish_run();
    end
endmodule